// File: doc/BRIEF.md
# Phase-Interleaved Video Memory Arbiter

This block lets a CPU bus and a video scan-out address generator share one asynchronous SRAM without wait states. It runs on the pixel clock and divides it by two into a system-clock phase. Each system cycle has two slots. While the phase is high, the CPU slot routes the CPU address, write data and write strobe to the RAM. While the phase is low, the video slot routes the scan-out address to the RAM. The rising pixel-clock edge that closes the video slot captures the returned byte as the pixel value.

A multiplexer selects the address; no tri-state buffers are used. The active-low write strobe never floats. It is held inactive during reset, during every video slot, and whenever no CPU is attached, so stray writes cannot overwrite the memory. The write-data bus is driven toward the RAM only while a CPU write is in progress. Only the red channel is derived from the pixel byte.

Top module: `vmem_phase_arbiter`

## Requirements
- R1: While `rst` is high, and at the first sample after it, `sys_clk_o` is 0 (video slot), `ram_we_n` is 1, `ram_wdata_oe` is 0 and `pix_byte` is 0.
- R2: Once out of reset, `sys_clk_o` inverts on every rising `clk` edge. The first edge after reset release makes it 1. A value of 1 marks the CPU slot and 0 marks the video slot.
- R3: `ram_addr` equals `cpu_addr` while `sys_clk_o` is 1, and equals `vid_addr` while it is 0.
- R4: `ram_we_n` is 0 only when `sys_clk_o` is 1 and both `cpu_present` and `cpu_wr` are 1; in every other case it is 1.
- R5: With `cpu_present` at 0, `cpu_wr` has no effect: `ram_we_n` stays 1 and `ram_wdata_oe` stays 0.
- R6: `ram_wdata_oe` is 1 exactly when `ram_we_n` is 0. `ram_wdata` equals `cpu_wdata` when `ram_wdata_oe` is 1, and is all zeros otherwise.
- R7: On each rising `clk` edge where `sys_clk_o` was 0, `pix_byte` takes the value of `ram_rdata`. It then holds that value for two clock periods, until the next such edge.
- R8: `pix_red` equals the top `RED_W` bits of `pix_byte`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | ADDR_W | CPU address bus |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_wr | input | 1 | CPU write request |
| cpu_present | input | 1 | High when a CPU drives the bus |
| vid_addr | input | ADDR_W | Scan-out address from the video counters |
| ram_rdata | input | DATA_W | Data returned by the SRAM |
| sys_clk_o | output | 1 | Half-rate system clock; high = CPU slot |
| ram_addr | output | ADDR_W | Multiplexed SRAM address |
| ram_we_n | output | 1 | SRAM write enable, active low |
| ram_wdata | output | DATA_W | Data driven toward the SRAM |
| ram_wdata_oe | output | 1 | Output enable for the write data |
| pix_byte | output | DATA_W | Latched pixel byte |
| pix_red | output | RED_W | Red channel value |

## Verification
A wrong slot register is visible at once. `ram_addr` shows the wrong source within the same pixel cycle. A strobe could then fire during a video slot, and `sys_clk_o` would stop alternating. A wrong capture edge or enable in the pixel latch gives a stale or skewed `pix_byte` one clock after the faulty edge. A behavioural model predicts every output on every cycle, so any such fault is reported within one or two pixel clocks of where it starts. The stimulus mixes CPU writes, CPU reads, write requests with no CPU present, and random read data.

// File: rtl/vmem_arb_pkg.sv
package vmem_arb_pkg;

    // Ownership of the shared RAM within one system-clock period.
    typedef enum logic {
        SLOT_VIDEO = 1'b0,
        SLOT_CPU   = 1'b1
    } slot_e;

    // A write is granted only in the CPU slot with a CPU attached and asking.
    function automatic logic write_grant(slot_e slot, logic present, logic wr);
        return (slot == SLOT_CPU) && present && wr;
    endfunction

    function automatic slot_e next_slot(slot_e slot);
        return (slot == SLOT_CPU) ? SLOT_VIDEO : SLOT_CPU;
    endfunction

endpackage

// File: rtl/vmem_slot_gen.sv
module vmem_slot_gen
    import vmem_arb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output slot_e slot_o
);

    slot_e slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= SLOT_VIDEO;
        end else begin
            slot_q <= next_slot(slot_q);
        end
    end

    assign slot_o = slot_q;

    // The slot alternates on every edge once reset has been released.
    assert_slot_alternates_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (slot_q != $past(slot_q)));

endmodule

// File: rtl/vmem_bus_mux.sv
module vmem_bus_mux
    import vmem_arb_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  slot_e             slot,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_wr,
    input  logic              cpu_present,
    input  logic [ADDR_W-1:0] vid_addr,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_we_n,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              ram_wdata_oe
);

    logic grant;

    always_comb begin
        grant = !rst && write_grant(slot, cpu_present, cpu_wr);
        unique case (slot)
            SLOT_CPU:   ram_addr = cpu_addr;
            SLOT_VIDEO: ram_addr = vid_addr;
            default:    ram_addr = vid_addr;
        endcase
        ram_we_n     = !grant;
        ram_wdata_oe = grant;
        ram_wdata    = grant ? cpu_wdata : '0;
    end

    assert_strobe_in_cpu_slot_R4: assert property (@(posedge clk) disable iff (rst)
        !ram_we_n |-> (slot == SLOT_CPU));

    assert_absent_cpu_no_write_R5: assert property (@(posedge clk) disable iff (rst)
        !cpu_present |-> (ram_we_n && !ram_wdata_oe));

    assert_drive_only_on_write_R6: assert property (@(posedge clk) disable iff (rst)
        ram_wdata_oe |-> !ram_we_n);

    assert_video_addr_routed_R3: assert property (@(posedge clk) disable iff (rst)
        (slot == SLOT_VIDEO) |-> (ram_addr == vid_addr));

endmodule

// File: rtl/vmem_pixel_latch.sv
module vmem_pixel_latch
    import vmem_arb_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int RED_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  slot_e             slot,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [DATA_W-1:0] pix_byte,
    output logic [RED_W-1:0]  pix_red
);

    localparam int RED_LSB = DATA_W - RED_W;

    logic [DATA_W-1:0] pix_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_q <= '0;
        end else if (slot == SLOT_VIDEO) begin
            pix_q <= ram_rdata;
        end
    end

    assign pix_byte = pix_q;
    assign pix_red  = pix_q[DATA_W-1:RED_LSB];

    assert_pixel_held_R7: assert property (@(posedge clk) disable iff (rst)
        (slot == SLOT_CPU) |=> $stable(pix_q));

    assert_pixel_capture_R7: assert property (@(posedge clk) disable iff (rst)
        (slot == SLOT_VIDEO) |=> (pix_q == $past(ram_rdata)));

endmodule

// File: rtl/vmem_phase_arbiter.sv
module vmem_phase_arbiter
    import vmem_arb_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8,
    parameter int RED_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_wr,
    input  logic              cpu_present,
    input  logic [ADDR_W-1:0] vid_addr,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              sys_clk_o,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_we_n,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              ram_wdata_oe,
    output logic [DATA_W-1:0] pix_byte,
    output logic [RED_W-1:0]  pix_red
);

    slot_e slot;

    vmem_slot_gen u_slot (
        .clk    (clk),
        .rst    (rst),
        .slot_o (slot)
    );

    vmem_bus_mux #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_mux (
        .clk          (clk),
        .rst          (rst),
        .slot         (slot),
        .cpu_addr     (cpu_addr),
        .cpu_wdata    (cpu_wdata),
        .cpu_wr       (cpu_wr),
        .cpu_present  (cpu_present),
        .vid_addr     (vid_addr),
        .ram_addr     (ram_addr),
        .ram_we_n     (ram_we_n),
        .ram_wdata    (ram_wdata),
        .ram_wdata_oe (ram_wdata_oe)
    );

    vmem_pixel_latch #(
        .DATA_W (DATA_W),
        .RED_W  (RED_W)
    ) u_pix (
        .clk       (clk),
        .rst       (rst),
        .slot      (slot),
        .ram_rdata (ram_rdata),
        .pix_byte  (pix_byte),
        .pix_red   (pix_red)
    );

    assign sys_clk_o = (slot == SLOT_CPU);

    // Reset holds the strobe inactive and the pixel cleared.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |-> ram_we_n);

    always_comb begin
        assert_red_slice_R8: assert (pix_red == pix_byte[DATA_W-1 -: RED_W]);
    end

endmodule

// File: tb/test_vmem_phase_arbiter.sv
module test_vmem_phase_arbiter;

    localparam int AW = 17;
    localparam int DW = 8;
    localparam int RW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_wr = 1'b0;
    logic          cpu_present = 1'b0;
    logic [AW-1:0] vid_addr = '0;
    logic [DW-1:0] ram_rdata = '0;
    logic          sys_clk_o;
    logic [AW-1:0] ram_addr;
    logic          ram_we_n;
    logic [DW-1:0] ram_wdata;
    logic          ram_wdata_oe;
    logic [DW-1:0] pix_byte;
    logic [RW-1:0] pix_red;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk; // 250 MHz

    vmem_phase_arbiter #(.ADDR_W(AW), .DATA_W(DW), .RED_W(RW)) i_vmem_phase_arbiter (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .cpu_present(cpu_present), .vid_addr(vid_addr),
        .ram_rdata(ram_rdata), .sys_clk_o(sys_clk_o), .ram_addr(ram_addr),
        .ram_we_n(ram_we_n), .ram_wdata(ram_wdata), .ram_wdata_oe(ram_wdata_oe),
        .pix_byte(pix_byte), .pix_red(pix_red)
    );

    // Behavioural reference: a cycle counter since reset and the last captured byte.
    int          m_cycles = 0;
    logic [DW-1:0] m_pix = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_cycles <= 0;
            m_pix    <= '0;
        end else begin
            if (m_cycles % 2 == 0) m_pix <= ram_rdata;
            m_cycles <= m_cycles + 1;
        end
    end

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        bit cpu_slot;
        bit wr;
        cpu_slot = (m_cycles % 2 == 1) && !rst;
        wr = cpu_slot && cpu_present && cpu_wr;
        check("R2 slot", sys_clk_o, cpu_slot);
        check("R3 address", ram_addr, cpu_slot ? cpu_addr : vid_addr);
        check("R4 strobe", ram_we_n, !wr);
        if (!cpu_present) check("R5 absent cpu strobe", ram_we_n, 1);
        check("R6 data enable", ram_wdata_oe, wr);
        check("R6 data value", ram_wdata, wr ? cpu_wdata : 0);
        check("R7 pixel", pix_byte, m_pix);
        check("R8 red", pix_red, m_pix[DW-1 -: RW]);
    endtask

    // mode: 0 random, 1 cpu write, 2 absent cpu with write request, 3 cpu read
    task automatic step(int mode);
        @(negedge clk);
        cpu_addr  = AW'($urandom);
        vid_addr  = AW'($urandom);
        cpu_wdata = DW'($urandom);
        ram_rdata = DW'($urandom);
        case (mode)
            1: begin cpu_present = 1; cpu_wr = 1; end
            2: begin cpu_present = 0; cpu_wr = 1; end
            3: begin cpu_present = 1; cpu_wr = 0; end
            default: begin cpu_present = 1'($urandom); cpu_wr = 1'($urandom); end
        endcase
        #1;
        compare_all();
    endtask

    initial begin
        // R1: reset state, including a write request that must be ignored
        cpu_present = 1; cpu_wr = 1;
        repeat (3) begin
            @(negedge clk); #1;
            check("R1 reset slot", sys_clk_o, 0);
            check("R1 reset strobe", ram_we_n, 1);
            check("R1 reset data enable", ram_wdata_oe, 0);
            check("R1 reset pixel", pix_byte, 0);
        end
        @(negedge clk); rst = 0; #1;
        check("R1 first sample after reset slot", sys_clk_o, 0);
        check("R1 first sample after reset pixel", pix_byte, 0);
        compare_all();
        repeat (40) step(1);   // R4 R6 writes every CPU slot
        repeat (40) step(2);   // R5 no CPU attached
        repeat (40) step(3);   // R3 R7 reads
        repeat (400) step(0);  // mixed
        // mid-run reset, then R2 first edge after release
        @(negedge clk); rst = 1; #1;
        check("R1 reset strobe mid-run", ram_we_n, 1);
        @(negedge clk); #1;
        check("R1 reset slot mid-run", sys_clk_o, 0);
        check("R1 reset pixel mid-run", pix_byte, 0);
        @(negedge clk); rst = 0; #1;
        @(negedge clk); #1;
        check("R2 first edge after release", sys_clk_o, 1);
        repeat (100) step(0);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule